// File: doc/BRIEF.md
# Debug Interrupt Deferral Controller

This block sits next to the retire stage of an in-order pipeline that retires at most one instruction per cycle. For every retiring instruction it receives one indication per debug event class. It keeps a sticky debug status word, and it decides whether a debug interrupt is taken. When one is taken, it also decides which return address and machine-state word are saved, what the new machine state is, and how the interrupt is classified: synchronous-precise, synchronous-imprecise or asynchronous.

The main job is deferral. An event recognised while the debug-enable bit of the machine-state word is clear does not interrupt. It sets its status bit and waits. When a later retiring instruction sets the enable bit again, the interrupt is taken if any status bit is still set. The saved address is then derived from that re-enabling instruction: its sequential successor, or its return target if it is a return-from-interrupt. Software clears status bits through a write-one-to-clear input.

Top module: `dbg_defer_ctl`

## Requirements
- R1: While reset is held and after it is released, every output is zero, including the status word.
- R2: An event in class 0 (instruction-address compare), 1 (return), 2 (trap), 3 (data-address compare), 4 (data-value compare), 7 (interrupt-taken) or 8 (unconditional) that arrives on a retiring instruction while the enable bit is 0 sets its status bit and raises no debug interrupt. Status bits stay set until a 1 on the matching bit of `statusClr`.
- R3: A retiring instruction that sets the enable bit from 0 to 1 while a status bit is still set causes `dbgIrq` in the next cycle. The saved address is that instruction's sequential successor, and `saveState` is the incoming machine-state word with the enable bit set.
- R4: If the re-enabling instruction is a return-from-interrupt, the saved address is its return target.
- R5: A re-enable with no status bit set raises no interrupt. This includes the case where all pending bits are cleared in the same cycle.
- R6: Branch-taken events (class 6) and instruction-complete events (class 5) that arrive while the enable bit is 0 leave the status word unchanged and raise nothing.
- R7: An instruction-complete event on an instruction that clears the enable bit raises no immediate interrupt and sets status bit 5. It is taken at the next re-enable as synchronous-imprecise.
- R8: With the enable bit at 1, a recognised event interrupts in the next cycle, and the winning class decides the outcome:
  - Class 7 saves `vecAddr` and is classed asynchronous.
  - Class 8 saves the sequential successor and is classed asynchronous.
  - Class 5 saves the successor, or the return target after a return, and is classed precise.
  - Any other class saves the instruction's own address and is classed precise.
- R9: `irqClass` encodes 0 for synchronous-precise, 1 for synchronous-imprecise and 2 for asynchronous. A deferred interrupt is classed as follows:
  - Classes 0, 1, 2 and 5 give 1.
  - Classes 7 and 8 give 2.
  - Classes 3 and 4 give 2 when `linkCfg` is 1, and 1 otherwise.
- R10: A trap event on a retiring instruction while the enable bit is 0 pulses `progTrapIrq` in the next cycle. The debug interrupt is still taken at a later re-enable.
- R11: On every taken interrupt, `newState` equals `saveState` with only the machine-check-enable bit kept and all other bits 0.
- R12: When several events compete, the lowest class number sets the address selection and the classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| retValid | input | 1 | An instruction retires this cycle |
| retPc | input | AW | Address of the retiring instruction |
| retSeqPc | input | AW | Sequential successor address |
| retTgtPc | input | AW | Return target of a return-from-interrupt |
| retIsRfi | input | 1 | Retiring instruction is a return-from-interrupt |
| retWrEn | input | 1 | Retiring instruction writes the enable bit |
| retWrEnVal | input | 1 | Value written to the enable bit |
| evIn | input | 9 | Debug events raised by the retiring instruction, one bit per class |
| statusClr | input | 9 | Write-one-to-clear for the status word |
| linkCfg | input | 1 | Linked data-compare configuration |
| vecAddr | input | AW | Handler entry address of the interrupt behind an interrupt-taken event |
| stateIn | input | MW | Current machine-state word, before the retiring instruction |
| dbgIrq | output | 1 | Debug interrupt taken (one-cycle pulse) |
| irqClass | output | 2 | Classification of the taken interrupt |
| saveAddr | output | AW | Saved return address |
| saveState | output | MW | Saved machine-state word |
| newState | output | MW | Machine-state word to install |
| progTrapIrq | output | 1 | Program trap interrupt pulse |
| statusOut | output | 9 | Sticky debug status word |

## Verification
The two functions that can fall in the same cycle are taking a deferred interrupt and updating the sticky status word. A re-enabling instruction may carry its own event, and software may clear pending bits in that very cycle. The bench provokes this by re-enabling while the clear input removes the only pending bit, and by re-enabling on an instruction that raises a new event. A behavioural reference model then judges whether an interrupt follows and which status bits survive. A second overlap is an immediate trap program interrupt together with new pending debug status; the bench checks that both the pulse and the later debug interrupt appear.

// File: rtl/dbgdefer_pkg.sv
package dbgdefer_pkg;
  localparam int NUM_EV    = 9;
  localparam int EV_IADDR  = 0;
  localparam int EV_RETURN = 1;
  localparam int EV_TRAP   = 2;
  localparam int EV_DADDR  = 3;
  localparam int EV_DVAL   = 4;
  localparam int EV_DONE   = 5;
  localparam int EV_BRANCH = 6;
  localparam int EV_INTR   = 7;
  localparam int EV_UNCOND = 8;

  typedef enum logic [1:0] {
    CLS_PRECISE   = 2'd0,
    CLS_IMPRECISE = 2'd1,
    CLS_ASYNC     = 2'd2
  } irqClass_e;

  typedef enum logic [1:0] {
    SEL_CUR = 2'd0,
    SEL_SEQ = 2'd1,
    SEL_TGT = 2'd2,
    SEL_VEC = 2'd3
  } addrSel_e;

  typedef struct packed {
    logic      take;
    addrSel_e  addrSel;
    logic      forceEn;
    irqClass_e cls;
  } ctrlStrobe_t;
endpackage

// File: rtl/dbgdefer_ctrl.sv
module dbgdefer_ctrl
  import dbgdefer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              retValid,
  input  logic [NUM_EV-1:0] evIn,
  input  logic [NUM_EV-1:0] statusClr,
  input  logic              enNow,
  input  logic              wrEn,
  input  logic              wrEnVal,
  input  logic              retIsRfi,
  input  logic              linkCfg,
  output ctrlStrobe_t       strobe,
  output logic              irqOut,
  output logic              progTrapOut,
  output logic [NUM_EV-1:0] statusQ
);
  function automatic int pickFirst(input logic [NUM_EV-1:0] v);
    int r;
    r = NUM_EV;
    for (int i = NUM_EV - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  logic [NUM_EV-1:0] rec;
  logic [NUM_EV-1:0] statusNxt;
  logic reEnable, clearingEn, doneDefer, immTake, defTake;
  int recWin, pendWin;

  // branch-taken and completion events are not recognised while disabled
  for (genvar g = 0; g < NUM_EV; g++) begin : g_rec
    if (g == EV_BRANCH || g == EV_DONE) begin : g_gated
      assign rec[g] = retValid & evIn[g] & enNow;
    end else begin : g_open
      assign rec[g] = retValid & evIn[g];
    end
  end

  assign statusNxt  = (statusQ & ~statusClr) | rec;
  assign reEnable   = retValid & wrEn & wrEnVal & ~enNow;
  assign clearingEn = retValid & wrEn & ~wrEnVal;
  assign recWin     = pickFirst(rec);
  assign pendWin    = pickFirst(statusNxt);
  assign doneDefer  = (recWin == EV_DONE) && clearingEn;
  assign immTake    = enNow && (|rec) && !doneDefer;
  assign defTake    = reEnable && (|statusNxt);

  always_comb begin
    strobe = '{take: 1'b0, addrSel: SEL_CUR, forceEn: 1'b0, cls: CLS_PRECISE};
    if (immTake) begin
      strobe.take = 1'b1;
      case (recWin)
        EV_INTR:   begin strobe.addrSel = SEL_VEC; strobe.cls = CLS_ASYNC; end
        EV_UNCOND: begin strobe.addrSel = SEL_SEQ; strobe.cls = CLS_ASYNC; end
        EV_DONE:   strobe.addrSel = retIsRfi ? SEL_TGT : SEL_SEQ;
        default:   strobe.addrSel = SEL_CUR;
      endcase
    end else if (defTake) begin
      strobe.take    = 1'b1;
      strobe.forceEn = 1'b1;
      strobe.addrSel = retIsRfi ? SEL_TGT : SEL_SEQ;
      case (pendWin)
        EV_DADDR, EV_DVAL: strobe.cls = linkCfg ? CLS_ASYNC : CLS_IMPRECISE;
        EV_INTR, EV_UNCOND: strobe.cls = CLS_ASYNC;
        default:           strobe.cls = CLS_IMPRECISE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ     <= '0;
      irqOut      <= 1'b0;
      progTrapOut <= 1'b0;
    end else begin
      statusQ     <= statusNxt;
      irqOut      <= strobe.take;
      progTrapOut <= retValid & evIn[EV_TRAP] & ~enNow;
    end
  end
endmodule

// File: rtl/dbgdefer_dp.sv
module dbgdefer_dp
  import dbgdefer_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MW      = 32,
  parameter int EN_BIT  = 9,
  parameter int MCE_BIT = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [AW-1:0] retPc,
  input  logic [AW-1:0] retSeqPc,
  input  logic [AW-1:0] retTgtPc,
  input  logic [AW-1:0] vecAddr,
  input  logic [MW-1:0] stateIn,
  output logic [AW-1:0] saveAddr,
  output logic [MW-1:0] saveState,
  output logic [MW-1:0] newState,
  output logic [1:0]    irqClass
);
  localparam logic [MW-1:0] EN_MASK  = MW'(1) << EN_BIT;
  localparam logic [MW-1:0] MCE_MASK = MW'(1) << MCE_BIT;

  logic [AW-1:0] addrPick;
  logic [MW-1:0] statePick;

  always_comb begin
    case (strobe.addrSel)
      SEL_SEQ: addrPick = retSeqPc;
      SEL_TGT: addrPick = retTgtPc;
      SEL_VEC: addrPick = vecAddr;
      default: addrPick = retPc;
    endcase
    statePick = strobe.forceEn ? (stateIn | EN_MASK) : stateIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      saveAddr  <= '0;
      saveState <= '0;
      newState  <= '0;
      irqClass  <= '0;
    end else if (strobe.take) begin
      saveAddr  <= addrPick;
      saveState <= statePick;
      newState  <= statePick & MCE_MASK;
      irqClass  <= strobe.cls;
    end
  end
endmodule

// File: rtl/dbg_defer_ctl.sv
module dbg_defer_ctl
  import dbgdefer_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MW      = 32,
  parameter int EN_BIT  = 9,
  parameter int MCE_BIT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retValid,
  input  logic [AW-1:0]     retPc,
  input  logic [AW-1:0]     retSeqPc,
  input  logic [AW-1:0]     retTgtPc,
  input  logic              retIsRfi,
  input  logic              retWrEn,
  input  logic              retWrEnVal,
  input  logic [NUM_EV-1:0] evIn,
  input  logic [NUM_EV-1:0] statusClr,
  input  logic              linkCfg,
  input  logic [AW-1:0]     vecAddr,
  input  logic [MW-1:0]     stateIn,
  output logic              dbgIrq,
  output logic [1:0]        irqClass,
  output logic [AW-1:0]     saveAddr,
  output logic [MW-1:0]     saveState,
  output logic [MW-1:0]     newState,
  output logic              progTrapIrq,
  output logic [NUM_EV-1:0] statusOut
);
  ctrlStrobe_t strobe;

  dbgdefer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .retValid(retValid), .evIn(evIn),
    .statusClr(statusClr), .enNow(stateIn[EN_BIT]), .wrEn(retWrEn),
    .wrEnVal(retWrEnVal), .retIsRfi(retIsRfi), .linkCfg(linkCfg),
    .strobe(strobe), .irqOut(dbgIrq), .progTrapOut(progTrapIrq),
    .statusQ(statusOut)
  );

  dbgdefer_dp #(.AW(AW), .MW(MW), .EN_BIT(EN_BIT), .MCE_BIT(MCE_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .retPc(retPc),
    .retSeqPc(retSeqPc), .retTgtPc(retTgtPc), .vecAddr(vecAddr),
    .stateIn(stateIn), .saveAddr(saveAddr), .saveState(saveState),
    .newState(newState), .irqClass(irqClass)
  );
endmodule

// File: rtl/dbg_defer_ctl_chk.sv
module dbg_defer_ctl_chk
  import dbgdefer_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MW      = 32,
  parameter int EN_BIT  = 9,
  parameter int MCE_BIT = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              retValid,
  input logic [AW-1:0]     retSeqPc,
  input logic [AW-1:0]     retTgtPc,
  input logic              retIsRfi,
  input logic              retWrEn,
  input logic              retWrEnVal,
  input logic [NUM_EV-1:0] evIn,
  input logic [NUM_EV-1:0] statusClr,
  input logic [MW-1:0]     stateIn,
  input logic              dbgIrq,
  input logic [1:0]        irqClass,
  input logic [AW-1:0]     saveAddr,
  input logic [MW-1:0]     saveState,
  input logic [MW-1:0]     newState,
  input logic              progTrapIrq,
  input logic [NUM_EV-1:0] statusOut
);
  localparam logic [MW-1:0] MCE_MASK = MW'(1) << MCE_BIT;

  // R2
  stay_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    retValid && !stateIn[EN_BIT] && !(retWrEn && retWrEnVal) |=> !dbgIrq);

  // R3
  reenable_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    retValid && retWrEn && retWrEnVal && !stateIn[EN_BIT] && !retIsRfi
      && ((statusOut & ~statusClr) != '0)
    |=> dbgIrq && saveAddr == $past(retSeqPc));

  // R4
  rfi_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    retValid && retWrEn && retWrEnVal && !stateIn[EN_BIT] && retIsRfi
      && ((statusOut & ~statusClr) != '0)
    |=> dbgIrq && saveAddr == $past(retTgtPc));

  // R6
  done_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    retValid && !stateIn[EN_BIT] && evIn[EV_DONE] && !statusOut[EV_DONE]
    |=> !statusOut[EV_DONE]);

  // R6
  branch_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    retValid && !stateIn[EN_BIT] && evIn[EV_BRANCH] && !statusOut[EV_BRANCH]
    |=> !statusOut[EV_BRANCH]);

  // R7
  done_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    retValid && stateIn[EN_BIT] && evIn == (NUM_EV'(1) << EV_DONE)
      && retWrEn && !retWrEnVal
    |=> !dbgIrq && statusOut[EV_DONE]);

  // R9
  deferred_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgIrq && !$past(stateIn[EN_BIT]) |-> irqClass != CLS_PRECISE);

  // R10
  prog_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    retValid && evIn[EV_TRAP] && !stateIn[EN_BIT] |=> progTrapIrq && statusOut[EV_TRAP]);

  // R11
  new_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    dbgIrq |-> newState == (saveState & MCE_MASK));
endmodule

bind dbg_defer_ctl dbg_defer_ctl_chk #(.AW(AW), .MW(MW), .EN_BIT(EN_BIT), .MCE_BIT(MCE_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .retValid(retValid), .retSeqPc(retSeqPc),
  .retTgtPc(retTgtPc), .retIsRfi(retIsRfi), .retWrEn(retWrEn),
  .retWrEnVal(retWrEnVal), .evIn(evIn), .statusClr(statusClr),
  .stateIn(stateIn), .dbgIrq(dbgIrq), .irqClass(irqClass),
  .saveAddr(saveAddr), .saveState(saveState), .newState(newState),
  .progTrapIrq(progTrapIrq), .statusOut(statusOut)
);

// File: tb/dbg_defer_ctl_tb.sv
module dbg_defer_ctl_tb;
  localparam int AW = 32, MW = 32, EN_BIT = 9, MCE_BIT = 12, NE = 9;

  logic clk = 1'b0, rstN = 1'b0;
  logic retValid = 0, retIsRfi = 0, retWrEn = 0, retWrEnVal = 0, linkCfg = 0;
  logic [AW-1:0] retPc = 0, retSeqPc = 0, retTgtPc = 0, vecAddr = 0;
  logic [NE-1:0] evIn = 0, statusClr = 0;
  logic [MW-1:0] stateIn = 0;
  logic dbgIrq, progTrapIrq;
  logic [1:0] irqClass;
  logic [AW-1:0] saveAddr;
  logic [MW-1:0] saveState, newState;
  logic [NE-1:0] statusOut;

  dbg_defer_ctl #(.AW(AW), .MW(MW), .EN_BIT(EN_BIT), .MCE_BIT(MCE_BIT)) u_dut (
    .clk(clk), .rstN(rstN), .retValid(retValid), .retPc(retPc),
    .retSeqPc(retSeqPc), .retTgtPc(retTgtPc), .retIsRfi(retIsRfi),
    .retWrEn(retWrEn), .retWrEnVal(retWrEnVal), .evIn(evIn),
    .statusClr(statusClr), .linkCfg(linkCfg), .vecAddr(vecAddr),
    .stateIn(stateIn), .dbgIrq(dbgIrq), .irqClass(irqClass),
    .saveAddr(saveAddr), .saveState(saveState), .newState(newState),
    .progTrapIrq(progTrapIrq), .statusOut(statusOut)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  string curReq = "R1";
  bit chkOn = 0;

  // reference model state
  logic mIrq, mProg;
  logic [1:0] mCls;
  logic [AW-1:0] mAddr;
  logic [MW-1:0] mSave, mNew;
  logic [NE-1:0] mStat;
  int irqSeen = 0;

  function automatic int firstSet(input logic [NE-1:0] v);
    for (int i = 0; i < NE; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIrq <= 0; mProg <= 0; mCls <= 0; mAddr <= 0; mSave <= 0; mNew <= 0; mStat <= 0;
    end else begin
      logic en, reen, imm, dfr, doneHold;
      logic [NE-1:0] rec, nxt;
      int w;
      en   = stateIn[EN_BIT];
      rec  = retValid ? evIn : '0;
      if (!en) begin rec[5] = 0; rec[6] = 0; end
      nxt  = (mStat & ~statusClr) | rec;
      reen = retValid && retWrEn && retWrEnVal && !en;
      doneHold = retValid && retWrEn && !retWrEnVal && firstSet(rec) == 5;
      imm  = en && rec != 0 && !doneHold;
      dfr  = reen && nxt != 0;
      mStat <= nxt;
      mIrq  <= imm || dfr;
      mProg <= retValid && evIn[2] && !en;
      if (imm) begin
        w = firstSet(rec);
        if (w == 7) begin mAddr <= vecAddr; mCls <= 2; end
        else if (w == 8) begin mAddr <= retSeqPc; mCls <= 2; end
        else if (w == 5) begin mAddr <= retIsRfi ? retTgtPc : retSeqPc; mCls <= 0; end
        else begin mAddr <= retPc; mCls <= 0; end
        mSave <= stateIn;
        mNew  <= stateIn & (MW'(1) << MCE_BIT);
      end else if (dfr) begin
        w = firstSet(nxt);
        mAddr <= retIsRfi ? retTgtPc : retSeqPc;
        if (w == 3 || w == 4) mCls <= linkCfg ? 2 : 1;
        else if (w == 7 || w == 8) mCls <= 2;
        else mCls <= 1;
        mSave <= stateIn | (MW'(1) << EN_BIT);
        mNew  <= (stateIn | (MW'(1) << EN_BIT)) & (MW'(1) << MCE_BIT);
      end
    end
  end

  task automatic cmp(input string nm, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      cmp("dbgIrq", 64'(dbgIrq), 64'(mIrq));
      cmp("progTrapIrq", 64'(progTrapIrq), 64'(mProg));
      cmp("statusOut", 64'(statusOut), 64'(mStat));
      cmp("irqClass", 64'(irqClass), 64'(mCls));
      cmp("saveAddr", 64'(saveAddr), 64'(mAddr));
      cmp("saveState", 64'(saveState), 64'(mSave));
      cmp("newState", 64'(newState), 64'(mNew));
      if (dbgIrq) irqSeen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one retiring slot, then wait to the sampling point
  task automatic slot(input bit v, input logic [NE-1:0] ev, input bit en,
                      input bit wr, input bit wrv, input bit rfi,
                      input logic [NE-1:0] clr);
    retValid = v; evIn = ev; retWrEn = wr; retWrEnVal = wrv; retIsRfi = rfi;
    statusClr = clr;
    retPc = $urandom; retSeqPc = retPc + 4; retTgtPc = $urandom; vecAddr = $urandom;
    stateIn = $urandom;
    stateIn[EN_BIT] = en;
    @(negedge clk); #1;
  endtask

  task automatic idle(input bit en);
    slot(0, '0, en, 0, 0, 0, '0);
  endtask

  initial begin
    #1;
    repeat (2) @(negedge clk);
    chkOn = 1;
    curReq = "R1";
    cmp("reset irq", 64'(dbgIrq), 0);
    cmp("reset status", 64'(statusOut), 0);
    #1; rstN = 1;
    idle(0);

    curReq = "R2"; // address compare while disabled goes pending
    slot(1, 9'h001, 0, 0, 0, 0, '0);
    idle(0); idle(0);
    cmp("R2 pending bit", 64'(statusOut), 64'h001);

    curReq = "R3"; // plain re-enable
    slot(1, '0, 0, 1, 1, 0, '0);
    cmp("R3 irq", 64'(dbgIrq), 1);
    cmp("R9 imprecise", 64'(irqClass), 1);
    curReq = "R11";
    idle(1);
    curReq = "R2"; // sticky until cleared
    cmp("R2 sticky", 64'(statusOut), 64'h001);
    slot(0, '0, 0, 0, 0, 0, 9'h001);
    cmp("R2 cleared", 64'(statusOut), 0);

    curReq = "R4"; // data compare, re-enable by return
    linkCfg = 0;
    slot(1, 9'h008, 0, 0, 0, 0, '0);
    slot(1, '0, 0, 1, 1, 1, '0);
    cmp("R4 irq", 64'(dbgIrq), 1);
    cmp("R9 linked=0", 64'(irqClass), 1);
    curReq = "R9";
    linkCfg = 1;
    slot(1, '0, 0, 1, 1, 0, '0);
    cmp("R9 linked=1", 64'(irqClass), 2);
    linkCfg = 0;
    slot(0, '0, 0, 0, 0, 0, 9'h1ff);

    curReq = "R5"; // nothing pending / cleared in same cycle
    slot(1, '0, 0, 1, 1, 0, '0);
    cmp("R5 no irq", 64'(dbgIrq), 0);
    slot(1, 9'h002, 0, 0, 0, 0, '0);
    slot(1, '0, 0, 1, 1, 0, 9'h002);
    cmp("R5 same-cycle clear", 64'(dbgIrq), 0);

    curReq = "R6"; // branch / completion ignored while disabled
    slot(1, 9'h060, 0, 0, 0, 0, '0);
    idle(0);
    cmp("R6 status", 64'(statusOut), 0);
    cmp("R6 irq", 64'(dbgIrq), 0);

    curReq = "R7"; // completion on instruction clearing enable
    slot(1, 9'h020, 1, 1, 0, 0, '0);
    cmp("R7 no irq", 64'(dbgIrq), 0);
    cmp("R7 pending", 64'(statusOut), 64'h020);
    slot(1, '0, 0, 1, 1, 0, '0);
    cmp("R7 later irq", 64'(dbgIrq), 1);
    cmp("R7 class", 64'(irqClass), 1);
    slot(0, '0, 1, 0, 0, 0, 9'h1ff);

    curReq = "R8"; // immediate takes
    slot(1, 9'h080, 1, 0, 0, 0, '0);
    cmp("R8 intr async", 64'(irqClass), 2);
    slot(1, 9'h100, 1, 0, 0, 0, '0);
    cmp("R8 uncond async", 64'(irqClass), 2);
    slot(1, 9'h001, 1, 0, 0, 0, '0);
    cmp("R8 precise", 64'(irqClass), 0);
    slot(1, 9'h020, 1, 0, 0, 1, '0);
    slot(0, '0, 1, 0, 0, 0, 9'h1ff);

    curReq = "R10"; // trap while disabled
    slot(1, 9'h004, 0, 0, 0, 0, '0);
    cmp("R10 prog trap", 64'(progTrapIrq), 1);
    cmp("R10 no dbg", 64'(dbgIrq), 0);
    slot(1, '0, 0, 1, 1, 0, '0);
    cmp("R10 later dbg", 64'(dbgIrq), 1);
    slot(0, '0, 1, 0, 0, 0, 9'h1ff);

    curReq = "R12"; // priority among pending
    slot(1, 9'h100, 0, 0, 0, 0, '0);
    slot(1, 9'h002, 0, 0, 0, 0, '0);
    slot(1, '0, 0, 1, 1, 0, '0);
    cmp("R12 lowest class wins", 64'(irqClass), 1);
    slot(1, 9'h180, 1, 0, 0, 0, 9'h1ff);
    cmp("R12 immediate winner", 64'(saveAddr), 64'(mAddr));

    curReq = "R9"; // random mix
    for (int k = 0; k < 600; k++) begin
      logic [NE-1:0] ev, cl;
      ev = ($urandom % 3 == 0) ? NE'($urandom) : '0;
      cl = ($urandom % 5 == 0) ? NE'($urandom) : '0;
      linkCfg = $urandom;
      slot($urandom % 4 != 0, ev, $urandom, $urandom, $urandom, $urandom, cl);
    end

    curReq = "R3";
    cmp("interrupts observed", 64'(irqSeen > 20), 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule